// File: doc/BRIEF.md
# Hamming SEC-DED Page Checker for NAND Flash

This block protects a NAND page of up to four 512-byte blocks with a Hamming code that corrects one flipped bit and detects two per block. It taps the byte stream between the controller and the flash. A page session opens on a start pulse, but only if the byte offset given with that pulse is a multiple of 512. Each block of 512 accepted bytes then yields its own 24-bit check word, formed from twelve complementary parity pairs. Nine pairs cover the byte index and three cover the bit index.

In write mode, the check words of all blocks of the page are streamed out as bytes once the final data byte has passed. The controller places them in the spare area after the data. In read mode, the block then takes in the check words read back from the spare area. It compares each one with the word it computed over the received data, and reports a two-bit verdict per block together with the position of a correctable bit. Repairing the buffer is left to software.

Top module: `ecc_page`

## Requirements
- R1: After reset, `blk_done`, `code_out_vld` and `stat_vld` are 0.
- R2: In the clock after the 512th accepted byte of a block, `blk_done` is 1 for one cycle and `blk_code` holds that block's check word. Pair n sits in bits [2n+1:2n], with the odd bit being the parity over the positions whose index bit is 1 and the even bit the parity over those where it is 0. Pairs 0..2 use data-bit index bits 0..2 and pairs 3..11 use byte index bits 0..8, the byte index counting from 0 within the block.
- R3: A start pulse is accepted only in the idle state with `start_ofs` equal to 0. A start with a nonzero offset is ignored: the bytes that follow produce no `blk_done`, no code bytes and no status.
- R4: In write mode, starting in the clock after the final data byte, the check words of blocks 0..N-1 are given out one byte per clock on `code_out` with `code_out_vld` high, 3*N bytes in all. Each word is sent with bits [7:0] first, then [15:8], then [23:16].
- R5: A page ends with the block whose 512th byte is accepted while `last_blk` is 1, or after block MAX_BLK-1, whichever comes first.
- R6: In read mode, after the final data block, the block takes 3*N stored-code bytes on `code_in` (qualified by `code_in_vld`, in the same byte order as R4). In the clock after the last of them, `stat_vld` is 1 for one cycle. `stat` then shows, 2 bits per block with block b at bits [2b+1:2b], the verdict for blocks below N and 0 for blocks not in the page.
- R7: The syndrome is stored XOR computed. The verdict is 0 when the syndrome is zero. It is 1 (correctable) when every pair of the syndrome has differing bits. It is 2 (error in the stored code) when exactly one syndrome bit is set. Any other syndrome gives 3 (uncorrectable).
- R8: For verdict 1, `err_byte` slice b (bits [9b+8:9b]) gives the byte offset of the flipped bit and `err_bit` slice b (bits [3b+2:3b]) gives its bit position. Both slices are 0 for any other verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start of a page transfer |
| start_ofs | input | 9 | Byte offset within a 512-byte block at the start |
| rd_mode | input | 1 | 1 = page read, 0 = page write, sampled with start |
| last_blk | input | 1 | Marks the current block as the last of the page |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| code_in_vld | input | 1 | Stored code byte strobe (read mode) |
| code_in | input | 8 | Stored code byte from the spare area |
| code_out_vld | output | 1 | Code byte valid (write mode) |
| code_out | output | 8 | Code byte for the spare area |
| blk_done | output | 1 | One-cycle pulse after each block's final byte |
| blk_code | output | 24 | Check word of the block just completed |
| stat_vld | output | 1 | One-cycle pulse: verdicts valid |
| stat | output | 2*MAX_BLK | Per-block verdict |
| err_byte | output | 9*MAX_BLK | Per-block byte offset of a correctable error |
| err_bit | output | 3*MAX_BLK | Per-block bit position of a correctable error |

## Verification
Any flaw in the running parity or the byte counter shows up as a wrong `blk_code` one clock after that block's 512th byte. A slip in the block count or in the end-of-page decision shows up as a missing or extra code byte, or as a misplaced status pulse, within a few clocks of the final block. Errors in syndrome decoding are visible only on the clock of `stat_vld`. For that reason the read cases place a different fault in each block: a data bit, two data bits and a stored-code bit. A short read then checks that verdicts left over from the earlier page are masked out.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int BLK_BYTES = 512;
  localparam int IDX_W     = $clog2(BLK_BYTES);
  localparam int PAIRS     = IDX_W + 3;
  localparam int CODE_W    = 2 * PAIRS;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    VERD_CLEAN  = 2'd0,
    VERD_FIXED  = 2'd1,
    VERD_CODE   = 2'd2,
    VERD_BROKEN = 2'd3
  } verdict_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DATA, PH_EMIT, PH_TAKE, PH_REPORT
  } phase_e;

  // Fold one byte at index idx into the running parity pairs.
  function automatic code_t code_step(input code_t c, input logic [IDX_W-1:0] idx,
                                      input logic [7:0] d);
    code_t      n;
    logic       p;
    logic [7:0] m;
    n = c;
    p = ^d;
    for (int j = 0; j < 3; j++) begin
      m = (j == 0) ? 8'hAA : ((j == 1) ? 8'hCC : 8'hF0);
      n[2*j+1] = n[2*j+1] ^ (^(d & m));
      n[2*j]   = n[2*j]   ^ (^(d & ~m));
    end
    for (int k = 0; k < IDX_W; k++) begin
      if (idx[k]) n[7+2*k] = n[7+2*k] ^ p;
      else        n[6+2*k] = n[6+2*k] ^ p;
    end
    return n;
  endfunction
endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
  import ecc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] data,
  output code_t      code_nxt,
  output logic       blk_end
);
  logic [IDX_W-1:0] cnt_q, cnt_n;
  code_t            acc_q, acc_n;

  assign code_nxt = code_step(acc_q, cnt_q, data);
  assign blk_end  = (cnt_q == IDX_W'(BLK_BYTES - 1));

  always_comb begin
    cnt_n = cnt_q;
    acc_n = acc_q;
    if (clr) begin
      cnt_n = '0;
      acc_n = '0;
    end else if (en) begin
      cnt_n = cnt_q + 1'b1;
      acc_n = blk_end ? '0 : code_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      acc_q <= acc_n;
    end
  end
endmodule

// File: rtl/ecc_codebuf.sv
module ecc_codebuf
  import ecc_pkg::*;
#(
  parameter int MAX_BLK = 4,
  localparam int BLK_W  = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    calc_we,
  input  logic [BLK_W-1:0]        calc_idx,
  input  code_t                   calc_val,
  input  logic                    stor_we,
  input  logic [BLK_W-1:0]        ptr_blk,
  input  logic [1:0]              ptr_sel,
  input  logic [7:0]              stor_byte,
  output logic [7:0]              rd_byte,
  output code_t [MAX_BLK-1:0]     calc_all,
  output code_t [MAX_BLK-1:0]     stor_all
);
  code_t [MAX_BLK-1:0] calc_q, stor_q;
  code_t               sel_word;

  assign calc_all = calc_q;
  assign stor_all = stor_q;
  assign sel_word = calc_q[ptr_blk];

  always_comb begin
    case (ptr_sel)
      2'd0:    rd_byte = sel_word[7:0];
      2'd1:    rd_byte = sel_word[15:8];
      default: rd_byte = sel_word[23:16];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calc_q <= '0;
      stor_q <= '0;
    end else begin
      if (calc_we) calc_q[calc_idx] <= calc_val;
      if (stor_we) begin
        case (ptr_sel)
          2'd0:    stor_q[ptr_blk][7:0]   <= stor_byte;
          2'd1:    stor_q[ptr_blk][15:8]  <= stor_byte;
          default: stor_q[ptr_blk][23:16] <= stor_byte;
        endcase
      end
    end
  end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_pkg::*;
(
  input  code_t            calc,
  input  code_t            stored,
  output verdict_e         verdict,
  output logic [IDX_W-1:0] loc_byte,
  output logic [2:0]       loc_bit
);
  code_t            syn;
  logic             all_split;
  logic [PAIRS-1:0] odd;

  assign syn = calc ^ stored;

  always_comb begin
    all_split = 1'b1;
    for (int n = 0; n < PAIRS; n++) begin
      odd[n]    = syn[2*n+1];
      all_split = all_split & (syn[2*n+1] ^ syn[2*n]);
    end
  end

  always_comb begin
    verdict  = VERD_BROKEN;
    loc_byte = '0;
    loc_bit  = '0;
    if (syn == '0) begin
      verdict = VERD_CLEAN;
    end else if (all_split) begin
      verdict  = VERD_FIXED;
      loc_bit  = odd[2:0];
      loc_byte = odd[PAIRS-1:3];
    end else if ($countones(syn) == 1) begin
      verdict = VERD_CODE;
    end
  end
endmodule

// File: rtl/ecc_page.sv
module ecc_page
  import ecc_pkg::*;
#(
  parameter int MAX_BLK = 4,
  localparam int BLK_W  = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [8:0]             start_ofs,
  input  logic                   rd_mode,
  input  logic                   last_blk,
  input  logic                   byte_vld,
  input  logic [7:0]             byte_data,
  input  logic                   code_in_vld,
  input  logic [7:0]             code_in,
  output logic                   code_out_vld,
  output logic [7:0]             code_out,
  output logic                   blk_done,
  output logic [23:0]            blk_code,
  output logic                   stat_vld,
  output logic [2*MAX_BLK-1:0]   stat,
  output logic [9*MAX_BLK-1:0]   err_byte,
  output logic [3*MAX_BLK-1:0]   err_bit
);
  phase_e           ph_q, ph_n;
  logic             rd_q, rd_n;
  logic [BLK_W-1:0] blk_q, blk_n, last_q, last_n, pb_q, pb_n;
  logic [1:0]       ps_q, ps_n;
  logic             acc_clr, acc_en, blk_end, step, ptr_end, done_n;
  code_t            code_nxt, blk_code_q;
  logic             blk_done_q;
  code_t [MAX_BLK-1:0] calc_all, stor_all;

  assign acc_en  = (ph_q == PH_DATA) && byte_vld;
  assign done_n  = acc_en && blk_end;
  assign ptr_end = (pb_q == last_q) && (ps_q == 2'd2);

  ecc_accum u_accum (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en), .data(byte_data),
    .code_nxt(code_nxt), .blk_end(blk_end)
  );

  ecc_codebuf #(.MAX_BLK(MAX_BLK)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .calc_we(done_n), .calc_idx(blk_q), .calc_val(code_nxt),
    .stor_we((ph_q == PH_TAKE) && code_in_vld), .ptr_blk(pb_q), .ptr_sel(ps_q),
    .stor_byte(code_in), .rd_byte(code_out),
    .calc_all(calc_all), .stor_all(stor_all)
  );

  always_comb begin
    ph_n    = ph_q;
    rd_n    = rd_q;
    blk_n   = blk_q;
    last_n  = last_q;
    pb_n    = pb_q;
    ps_n    = ps_q;
    acc_clr = 1'b0;
    step    = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start && (start_ofs == '0)) begin
          ph_n    = PH_DATA;
          rd_n    = rd_mode;
          blk_n   = '0;
          acc_clr = 1'b1;
        end
      end
      PH_DATA: begin
        if (done_n) begin
          if (last_blk || (blk_q == BLK_W'(MAX_BLK - 1))) begin
            last_n = blk_q;
            pb_n   = '0;
            ps_n   = '0;
            ph_n   = rd_q ? PH_TAKE : PH_EMIT;
          end else begin
            blk_n = blk_q + 1'b1;
          end
        end
      end
      PH_EMIT: begin
        step = 1'b1;
        if (ptr_end) ph_n = PH_IDLE;
      end
      PH_TAKE: begin
        if (code_in_vld) begin
          step = 1'b1;
          if (ptr_end) ph_n = PH_REPORT;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
    if (step) begin
      if (ps_q == 2'd2) begin
        ps_n = '0;
        pb_n = pb_q + 1'b1;
      end else begin
        ps_n = ps_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      rd_q       <= 1'b0;
      blk_q      <= '0;
      last_q     <= '0;
      pb_q       <= '0;
      ps_q       <= '0;
      blk_done_q <= 1'b0;
      blk_code_q <= '0;
    end else begin
      ph_q       <= ph_n;
      rd_q       <= rd_n;
      blk_q      <= blk_n;
      last_q     <= last_n;
      pb_q       <= pb_n;
      ps_q       <= ps_n;
      blk_done_q <= done_n;
      if (done_n) blk_code_q <= code_nxt;
    end
  end

  assign blk_done     = blk_done_q;
  assign blk_code     = blk_code_q;
  assign code_out_vld = (ph_q == PH_EMIT);
  assign stat_vld     = (ph_q == PH_REPORT);

  for (genvar b = 0; b < MAX_BLK; b++) begin : g_blk
    verdict_e         v;
    logic [IDX_W-1:0] lb;
    logic [2:0]       lt;
    logic             used;
    ecc_classify u_cls (
      .calc(calc_all[b]), .stored(stor_all[b]),
      .verdict(v), .loc_byte(lb), .loc_bit(lt)
    );
    assign used              = (BLK_W'(b) <= last_q);
    assign stat[2*b +: 2]    = used ? v  : VERD_CLEAN;
    assign err_byte[9*b +: 9] = used ? lb : '0;
    assign err_bit[3*b +: 3]  = used ? lt : '0;
  end
endmodule

// File: rtl/ecc_page_chk.sv
module ecc_page_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_vld,
  input logic code_in_vld,
  input logic code_out_vld,
  input logic blk_done,
  input logic stat_vld
);
  // R2
  blk_done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> $past(byte_vld));
  // R4
  emit_with_last_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_out_vld) |-> blk_done);
  // R6
  stat_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |=> !stat_vld);
  // R6
  stat_after_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |-> $past(code_in_vld));
endmodule

bind ecc_page ecc_page_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .code_in_vld(code_in_vld),
  .code_out_vld(code_out_vld), .blk_done(blk_done), .stat_vld(stat_vld)
);

// File: tb/test_ecc_page.sv
module test_ecc_page;
  localparam int MB = 4;

  logic clk, rst_n, start, rd_mode, last_blk, byte_vld, code_in_vld;
  logic [8:0] start_ofs;
  logic [7:0] byte_data, code_in, code_out;
  logic code_out_vld, blk_done, stat_vld;
  logic [23:0] blk_code;
  logic [2*MB-1:0] stat;
  logic [9*MB-1:0] err_byte;
  logic [3*MB-1:0] err_bit;

  ecc_page #(.MAX_BLK(MB)) i_ecc_page (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ofs(start_ofs), .rd_mode(rd_mode),
    .last_blk(last_blk), .byte_vld(byte_vld), .byte_data(byte_data),
    .code_in_vld(code_in_vld), .code_in(code_in), .code_out_vld(code_out_vld),
    .code_out(code_out), .blk_done(blk_done), .blk_code(blk_code),
    .stat_vld(stat_vld), .stat(stat), .err_byte(err_byte), .err_bit(err_bit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0, blk_seen = 0;
  bit finished = 0;
  logic [23:0] exp_words[$];
  logic [7:0]  exp_bytes[$];
  logic [7:0]  txd [0:2047];
  logic [23:0] clean [0:MB-1];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_code(input int blk);
    logic [23:0] c = '0;
    for (int i = 0; i < 512; i++)
      for (int b = 0; b < 8; b++)
        if (txd[blk*512+i][b]) begin
          for (int k = 0; k < 9; k++) c[6+2*k+((i>>k)&1)] ^= 1'b1;
          for (int j = 0; j < 3; j++) c[2*j+((b>>j)&1)] ^= 1'b1;
        end
    return c;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 2048; i++) txd[i] = 8'((i * 37) ^ (seed * 11) ^ (i >> 3));
    for (int b = 0; b < MB; b++) clean[b] = ref_code(b);
  endtask

  // monitor: scoreboard for block words and code bytes
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (blk_done) begin
        blk_seen++;
        if (exp_words.size() == 0) check(0, "R2/R3 unexpected blk_done", blk_code, 0);
        else begin
          logic [23:0] w;
          w = exp_words.pop_front();
          check(blk_code == w, "R2 blk_code", blk_code, w);
        end
      end
      if (code_out_vld) begin
        if (exp_bytes.size() == 0) check(0, "R4/R5 unexpected code byte", code_out, 0);
        else begin
          logic [7:0] e;
          e = exp_bytes.pop_front();
          check(code_out == e, "R4 code_out", code_out, e);
        end
      end
    end
  end

  task automatic send_data(input int nblk, input bit rd, input bit mark_last,
                           input logic [8:0] ofs);
    @(posedge clk); #2;
    start = 1'b1; start_ofs = ofs; rd_mode = rd;
    @(posedge clk); #2;
    start = 1'b0;
    for (int b = 0; b < nblk; b++)
      for (int i = 0; i < 512; i++) begin
        byte_vld = 1'b1; byte_data = txd[b*512+i];
        last_blk = mark_last && (b == nblk - 1);
        @(posedge clk); #2;
      end
    byte_vld = 1'b0; last_blk = 1'b0;
  endtask

  task automatic write_page(input int nblk, input bit mark_last);
    for (int b = 0; b < nblk; b++) exp_words.push_back(ref_code(b));
    for (int b = 0; b < nblk; b++)
      for (int s = 0; s < 3; s++) exp_bytes.push_back(clean[b][8*s +: 8]);
    send_data(nblk, 1'b0, mark_last, 9'd0);
    repeat (3 * nblk + 4) @(posedge clk);
    @(negedge clk);
    check(exp_bytes.size() == 0 && exp_words.size() == 0, "R5 all codes emitted",
          exp_bytes.size(), 0);
  endtask

  task automatic send_codes(input int nblk, input logic [23:0] flip3);
    for (int b = 0; b < nblk; b++)
      for (int s = 0; s < 3; s++) begin
        code_in_vld = 1'b1;
        code_in = (clean[b] ^ ((b == 3) ? flip3 : 24'h0)) >> (8 * s);
        @(posedge clk); #2;
      end
    code_in_vld = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 0; start_ofs = 0; rd_mode = 0; last_blk = 0;
    byte_vld = 0; byte_data = 0; code_in_vld = 0; code_in = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(!blk_done && !code_out_vld && !stat_vld, "R1 reset outputs",
          {blk_done, code_out_vld, stat_vld}, 0);

    // two-block write ended by last_blk (R2, R4, R5)
    fill(1);
    write_page(2, 1'b1);

    // unaligned start must be ignored (R3)
    fill(2);
    blk_seen = 0;
    send_data(1, 1'b0, 1'b1, 9'd5);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(blk_seen == 0 && !code_out_vld, "R3 unaligned start ignored", blk_seen, 0);

    // full four-block write without last_blk (R5)
    fill(3);
    write_page(4, 1'b0);

    // four-block read with one fault per block (R6, R7, R8)
    fill(4);
    txd[512 + 300][5] = ~txd[512 + 300][5];
    txd[1024 + 10][0] = ~txd[1024 + 10][0];
    txd[1024 + 11][0] = ~txd[1024 + 11][0];
    for (int b = 0; b < 4; b++) exp_words.push_back(ref_code(b));
    send_data(4, 1'b1, 1'b0, 9'd0);
    send_codes(4, 24'h000200);
    check(stat_vld == 1'b1, "R6 stat_vld after last code byte", stat_vld, 1);
    check(stat[1:0] == 2'd0, "R7 block0 clean", stat[1:0], 0);
    check(stat[3:2] == 2'd1, "R7 block1 correctable", stat[3:2], 1);
    check(err_byte[17:9] == 9'd300 && err_bit[5:3] == 3'd5, "R8 block1 location",
          {err_byte[17:9], err_bit[5:3]}, {9'd300, 3'd5});
    check(stat[5:4] == 2'd3, "R7 block2 double error", stat[5:4], 3);
    check(stat[7:6] == 2'd2, "R7 block3 stored code error", stat[7:6], 2);
    check(err_byte[8:0] == 0 && err_byte[35:18] == 0 && err_bit[2:0] == 0 && err_bit[11:6] == 0,
          "R8 no location unless correctable", {err_byte, err_bit}, 0);
    @(negedge clk);
    check(stat_vld == 1'b0, "R6 stat_vld single cycle", stat_vld, 0);

    // one-block read, stale blocks masked (R6, R8)
    fill(5);
    txd[0][0] = ~txd[0][0];
    exp_words.push_back(ref_code(0));
    send_data(1, 1'b1, 1'b1, 9'd0);
    send_codes(1, 24'h0);
    check(stat_vld == 1'b1 && stat == 8'h01, "R6 short page verdicts", stat, 8'h01);
    check(err_byte[8:0] == 0 && err_bit[2:0] == 0, "R8 location byte0 bit0",
          {err_byte[8:0], err_bit[2:0]}, 0);
    check(exp_words.size() == 0, "R2 all block words seen", exp_words.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule